// File: doc/BRIEF.md
# Power Domain Low-Power Sequencer

This block decides when a single power domain is switched off and back on, and drives the power switch and isolation clamp of that domain in a safe order. The decision can come from one of three places, chosen by a control mode. In software mode, explicit on and off requests decide, and they count only while the assigned core is running. In CPU-mode control, the domain powers down when a chosen core enters a configured power mode. In setpoint control, it powers down when the current system setpoint is flagged in a 16-bit membership map.

Before a power-down the block can ask for the state of the domain to be saved, and it waits for a completion handshake before opening the switch. On power-up it closes the switch first and keeps the isolation clamp on for a settle window of a set number of cycles. It can then issue a one-cycle restore request, either because the assigned core is back in RUN or because the current setpoint is flagged in a separate restore map. A sequence that has started always runs to its end. A trigger change that arrives part way through is acted on only after the sequence completes.

Top module: `pd_lp_seq`

## Requirements
- R1: After reset the domain is powered: `psw_off`=0, `iso_on`=0, `save_req`=0, `restore_req`=0, `dom_status`=0.
- R2: With `cfg_ctrl_mode`=0 (or the unused code 3), the domain follows software requests. A `sw_off_req` pulse powers it down and a `sw_on_req` pulse powers it up, with off taking priority if both are high. Requests made while the assigned core's mode is not RUN (code 0) are ignored.
- R3: With `cfg_ctrl_mode`=1, the domain powers down while the assigned core's mode equals `cfg_tgt_mode` and powers up when it differs. The mode codes are RUN=0, WAIT=1, STOP=2 and SUSPEND=3.
- R4: `cfg_core_sel`=0 assigns `core0_mode` and `cfg_core_sel`=1 assigns `core1_mode`. The core that is not assigned has no effect.
- R5: With `cfg_ctrl_mode`=2, the domain powers down while bit `sp_idx` of `cfg_sp_map` is 1 and powers up when that bit is 0.
- R6: In modes 1 and 2, a matching trigger powers the domain down only when `cfg_off_en`=1.
- R7: On power-down, `iso_on` rises one cycle before `psw_off` rises. `psw_off`=1 never occurs without `iso_on`=1.
- R8: With `cfg_save_en`=1, a power-down first raises `save_req` and holds it, with isolation and the switch untouched, until `save_done` is sampled high. The sequence then continues. With `cfg_save_en`=0, isolation follows the trigger in the next cycle.
- R9: On power-up, `psw_off` falls first and `iso_on` stays high for exactly SETTLE_CYC further cycles (default 4) before it falls.
- R10: In the cycle in which `iso_on` falls at the end of a power-up, `restore_req` pulses for one cycle if either (`cfg_rst_run_en`=1 and the assigned core's mode is RUN) or bit `sp_idx` of `cfg_rst_sp_map` is 1. Otherwise it stays 0.
- R11: `dom_status` encodes 0 = powered, 1 = switched off, 2 = in transition (saving, isolating or settling).
- R12: A trigger change during a save, isolate or settle step is deferred: the running sequence completes first, and the new target is then acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl_mode | input | 2 | 0 software, 1 CPU mode, 2 setpoint, 3 as 0 |
| cfg_core_sel | input | 1 | Assigned core (0 or 1) |
| cfg_tgt_mode | input | 2 | CPU mode that triggers power-down in mode 1 |
| cfg_sp_map | input | 16 | Setpoints that trigger power-down in mode 2 |
| cfg_save_en | input | 1 | Request state save before power-down |
| cfg_off_en | input | 1 | Allow hardware-triggered power-down |
| cfg_rst_run_en | input | 1 | Restore on power-up when assigned core is in RUN |
| cfg_rst_sp_map | input | 16 | Setpoints that request restore on power-up |
| core0_mode | input | 2 | Current power mode of core 0 |
| core1_mode | input | 2 | Current power mode of core 1 |
| sp_idx | input | 4 | Current system setpoint |
| sw_off_req | input | 1 | Software power-off pulse |
| sw_on_req | input | 1 | Software power-on pulse |
| save_done | input | 1 | State save complete |
| psw_off | output | 1 | Power switch open |
| iso_on | output | 1 | Isolation clamp active |
| save_req | output | 1 | State save request |
| restore_req | output | 1 | One-cycle state restore request |
| dom_status | output | 2 | Domain status code |

## Verification
The bench samples the power-down edges cycle by cycle. A design that opened the switch together with isolation, or before it, would show `psw_off` high on the first cycle in which `iso_on` is high. It counts the isolation-held cycles after the switch closes, so a settle counter that is off by one shows up as a clamp released one cycle early or late. It holds `save_done` low for several cycles and checks that nothing moves, which exposes a design that opens the switch without waiting. It also withdraws the trigger mid-save, so a design that aborted or reordered the running sequence, rather than finishing it, would never show the switched-off state. Software requests made while the core is asleep, the core that is not assigned, setpoints outside the map, and `cfg_off_en`=0 are all checked to leave the domain powered.

// File: rtl/pd_lp_pkg.sv
package pd_lp_pkg;

    localparam int MODE_W = 2;
    localparam int SP_N   = 16;
    localparam int SP_W   = $clog2(SP_N);

    localparam logic [MODE_W-1:0] CPU_RUN = 2'd0;

    typedef enum logic [1:0] {
        CTRL_SW  = 2'd0,
        CTRL_CPU = 2'd1,
        CTRL_SP  = 2'd2,
        CTRL_RSV = 2'd3
    } ctrl_mode_e;

    typedef enum logic [2:0] {
        PS_ON     = 3'd0,
        PS_SAVE   = 3'd1,
        PS_ISO    = 3'd2,
        PS_OFF    = 3'd3,
        PS_SETTLE = 3'd4
    } pwr_state_e;

    localparam logic [1:0] STAT_ON    = 2'd0;
    localparam logic [1:0] STAT_OFF   = 2'd1;
    localparam logic [1:0] STAT_TRANS = 2'd2;

endpackage

// File: rtl/pd_lp_trig.sv
module pd_lp_trig
    import pd_lp_pkg::*;
#(
    parameter int N_SP = SP_N,
    localparam int IDX_W = $clog2(N_SP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_ctrl_mode,
    input  logic              cfg_core_sel,
    input  logic [MODE_W-1:0] cfg_tgt_mode,
    input  logic [N_SP-1:0]   cfg_sp_map,
    input  logic              cfg_off_en,
    input  logic              cfg_rst_run_en,
    input  logic [N_SP-1:0]   cfg_rst_sp_map,
    input  logic [MODE_W-1:0] core0_mode,
    input  logic [MODE_W-1:0] core1_mode,
    input  logic [IDX_W-1:0]  sp_idx,
    input  logic              sw_off_req,
    input  logic              sw_on_req,
    output logic              tgt_off,
    output logic              restore_hit
);

    typedef struct packed {
        logic sw_off;
    } trig_reg_t;

    trig_reg_t   tr_d, tr_q;
    logic [MODE_W-1:0] core_mode;
    logic        core_run;
    ctrl_mode_e  mode;

    always_comb begin
        mode      = ctrl_mode_e'(cfg_ctrl_mode);
        core_mode = cfg_core_sel ? core1_mode : core0_mode;
        core_run  = (core_mode == CPU_RUN);

        tr_d = tr_q;
        if (core_run) begin
            if (sw_off_req)
                tr_d.sw_off = 1'b1;
            else if (sw_on_req)
                tr_d.sw_off = 1'b0;
        end

        unique case (mode)
            CTRL_CPU: tgt_off = cfg_off_en && (core_mode == cfg_tgt_mode);
            CTRL_SP:  tgt_off = cfg_off_en && cfg_sp_map[sp_idx];
            default:  tgt_off = tr_d.sw_off;
        endcase

        restore_hit = (cfg_rst_run_en && core_run) || cfg_rst_sp_map[sp_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tr_q <= '0;
        else
            tr_q <= tr_d;
    end

endmodule

// File: rtl/pd_lp_fsm.sv
module pd_lp_fsm
    import pd_lp_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tgt_off,
    input  logic       restore_hit,
    input  logic       cfg_save_en,
    input  logic       save_done,
    output logic       psw_off,
    output logic       iso_on,
    output logic       save_req,
    output logic       restore_req,
    output logic [1:0] dom_status
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        pwr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             rst_pulse;
    } fsm_reg_t;

    fsm_reg_t f_d, f_q;

    always_comb begin
        f_d           = f_q;
        f_d.rst_pulse = 1'b0;
        unique case (f_q.st)
            PS_ON: begin
                if (tgt_off)
                    f_d.st = cfg_save_en ? PS_SAVE : PS_ISO;
            end
            PS_SAVE: begin
                if (save_done)
                    f_d.st = PS_ISO;
            end
            PS_ISO: begin
                f_d.st = PS_OFF;
            end
            PS_OFF: begin
                if (!tgt_off) begin
                    f_d.st  = PS_SETTLE;
                    f_d.cnt = '0;
                end
            end
            PS_SETTLE: begin
                if (f_q.cnt == CNT_LAST) begin
                    f_d.st        = PS_ON;
                    f_d.rst_pulse = restore_hit;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            default: f_d.st = PS_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st        <= PS_ON;
            f_q.cnt       <= '0;
            f_q.rst_pulse <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        psw_off     = (f_q.st == PS_OFF);
        iso_on      = (f_q.st == PS_ISO) || (f_q.st == PS_OFF) || (f_q.st == PS_SETTLE);
        save_req    = (f_q.st == PS_SAVE);
        restore_req = f_q.rst_pulse;
        unique case (f_q.st)
            PS_ON:   dom_status = STAT_ON;
            PS_OFF:  dom_status = STAT_OFF;
            default: dom_status = STAT_TRANS;
        endcase
    end

endmodule

// File: rtl/pd_lp_seq.sv
module pd_lp_seq
    import pd_lp_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_ctrl_mode,
    input  logic        cfg_core_sel,
    input  logic [1:0]  cfg_tgt_mode,
    input  logic [15:0] cfg_sp_map,
    input  logic        cfg_save_en,
    input  logic        cfg_off_en,
    input  logic        cfg_rst_run_en,
    input  logic [15:0] cfg_rst_sp_map,
    input  logic [1:0]  core0_mode,
    input  logic [1:0]  core1_mode,
    input  logic [3:0]  sp_idx,
    input  logic        sw_off_req,
    input  logic        sw_on_req,
    input  logic        save_done,
    output logic        psw_off,
    output logic        iso_on,
    output logic        save_req,
    output logic        restore_req,
    output logic [1:0]  dom_status
);

    logic tgt_off;
    logic restore_hit;

    pd_lp_trig #(.N_SP(SP_N)) trig_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_ctrl_mode  (cfg_ctrl_mode),
        .cfg_core_sel   (cfg_core_sel),
        .cfg_tgt_mode   (cfg_tgt_mode),
        .cfg_sp_map     (cfg_sp_map),
        .cfg_off_en     (cfg_off_en),
        .cfg_rst_run_en (cfg_rst_run_en),
        .cfg_rst_sp_map (cfg_rst_sp_map),
        .core0_mode     (core0_mode),
        .core1_mode     (core1_mode),
        .sp_idx         (sp_idx),
        .sw_off_req     (sw_off_req),
        .sw_on_req      (sw_on_req),
        .tgt_off        (tgt_off),
        .restore_hit    (restore_hit)
    );

    pd_lp_fsm #(.SETTLE_CYC(SETTLE_CYC)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgt_off     (tgt_off),
        .restore_hit (restore_hit),
        .cfg_save_en (cfg_save_en),
        .save_done   (save_done),
        .psw_off     (psw_off),
        .iso_on      (iso_on),
        .save_req    (save_req),
        .restore_req (restore_req),
        .dom_status  (dom_status)
    );

endmodule

// File: rtl/pd_lp_seq_chk.sv
module pd_lp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       save_done,
    input logic       psw_off,
    input logic       iso_on,
    input logic       save_req,
    input logic       restore_req,
    input logic [1:0] dom_status
);

    // R7
    switch_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_off |-> iso_on);

    // R7
    iso_leads_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psw_off) |-> $past(iso_on));

    // R8
    save_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_done) |=> save_req);

    // R8
    save_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |-> (!psw_off && !iso_on));

    // R9
    switch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psw_off) |-> iso_on);

    // R10
    restore_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> (!iso_on && !psw_off && dom_status == 2'd0));

    // R11
    status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_status == 2'd1) |-> psw_off);

endmodule

bind pd_lp_seq pd_lp_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_done   (save_done),
    .psw_off     (psw_off),
    .iso_on      (iso_on),
    .save_req    (save_req),
    .restore_req (restore_req),
    .dom_status  (dom_status)
);

// File: tb/pd_lp_seq_tb_top.sv
module pd_lp_seq_tb_top;

    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_ctrl_mode = 2'd0;
    logic        cfg_core_sel = 1'b0;
    logic [1:0]  cfg_tgt_mode = 2'd0;
    logic [15:0] cfg_sp_map = '0;
    logic        cfg_save_en = 1'b0;
    logic        cfg_off_en = 1'b0;
    logic        cfg_rst_run_en = 1'b0;
    logic [15:0] cfg_rst_sp_map = '0;
    logic [1:0]  core0_mode = 2'd0;
    logic [1:0]  core1_mode = 2'd0;
    logic [3:0]  sp_idx = '0;
    logic        sw_off_req = 1'b0;
    logic        sw_on_req = 1'b0;
    logic        save_done = 1'b0;
    logic        psw_off, iso_on, save_req, restore_req;
    logic [1:0]  dom_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pd_lp_seq #(.SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_ctrl_mode(cfg_ctrl_mode), .cfg_core_sel(cfg_core_sel),
        .cfg_tgt_mode(cfg_tgt_mode), .cfg_sp_map(cfg_sp_map),
        .cfg_save_en(cfg_save_en), .cfg_off_en(cfg_off_en),
        .cfg_rst_run_en(cfg_rst_run_en), .cfg_rst_sp_map(cfg_rst_sp_map),
        .core0_mode(core0_mode), .core1_mode(core1_mode), .sp_idx(sp_idx),
        .sw_off_req(sw_off_req), .sw_on_req(sw_on_req), .save_done(save_done),
        .psw_off(psw_off), .iso_on(iso_on), .save_req(save_req),
        .restore_req(restore_req), .dom_status(dom_status)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // call at the negedge where the trigger was applied
    task automatic expect_down(input string req);
        step(1);
        check(req, "iso first", iso_on, 1);
        check("R7", "switch still closed", psw_off, 0);
        check("R11", "status transition", dom_status, 2);
        step(1);
        check(req, "switch open", psw_off, 1);
        check("R11", "status off", dom_status, 1);
    endtask

    task automatic expect_up(input string req, input int rst_exp);
        step(1);
        check(req, "switch closed", psw_off, 0);
        check("R9", "iso held at close", iso_on, 1);
        check("R11", "status settle", dom_status, 2);
        for (int i = 1; i < SETTLE; i++) begin
            step(1);
            check("R9", "iso held in settle", iso_on, 1);
        end
        step(1);
        check("R9", "iso released", iso_on, 0);
        check("R11", "status on", dom_status, 0);
        check("R10", "restore pulse", restore_req, rst_exp);
        step(1);
        check("R10", "restore one cycle", restore_req, 0);
    endtask

    task automatic expect_on(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            step(1);
            check(req, "stays powered", {iso_on, psw_off, dom_status}, 0);
        end
    endtask

    task automatic pulse_sw(input bit off);
        if (off) sw_off_req = 1'b1; else sw_on_req = 1'b1;
        @(posedge clk);
        #1;
        sw_off_req = 1'b0;
        sw_on_req  = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "psw_off", psw_off, 0);
        check("R1", "iso_on", iso_on, 0);
        check("R1", "save_req", save_req, 0);
        check("R1", "restore_req", restore_req, 0);
        check("R1", "status", dom_status, 0);
    endtask

    task automatic t_sw();
        cfg_ctrl_mode = 2'd0;
        sw_off_req = 1'b1;
        step(1);
        sw_off_req = 1'b0;
        check("R2", "iso after sw off", iso_on, 1);
        step(1);
        check("R2", "switch after sw off", psw_off, 1);
        sw_on_req = 1'b1;
        expect_up("R2", 0);
        sw_on_req = 1'b0;
        core0_mode = 2'd2;
        pulse_sw(1'b1);
        expect_on("R2", 3);
        core0_mode = 2'd0;
        step(1);
    endtask

    task automatic t_cpu();
        cfg_ctrl_mode = 2'd1; cfg_tgt_mode = 2'd2; cfg_off_en = 1'b1; cfg_core_sel = 1'b0;
        core0_mode = 2'd1;
        expect_on("R3", 2);
        core0_mode = 2'd2;
        expect_down("R3");
        core0_mode = 2'd0;
        expect_up("R3", 0);
        cfg_core_sel = 1'b1;
        core0_mode = 2'd2;
        expect_on("R4", 3);
        core1_mode = 2'd2;
        expect_down("R4");
        core1_mode = 2'd0;
        expect_up("R4", 0);
        core0_mode = 2'd0; cfg_core_sel = 1'b0;
        cfg_off_en = 1'b0;
        core0_mode = 2'd2;
        expect_on("R6", 3);
        core0_mode = 2'd0; cfg_off_en = 1'b1;
        step(1);
    endtask

    task automatic t_sp();
        cfg_ctrl_mode = 2'd2; cfg_sp_map = 16'h0120;
        sp_idx = 4'd4;
        expect_on("R5", 2);
        sp_idx = 4'd8;
        expect_down("R5");
        sp_idx = 4'd15;
        expect_up("R5", 0);
        sp_idx = 4'd5;
        expect_down("R5");
        sp_idx = 4'd0;
        expect_up("R5", 0);
        cfg_off_en = 1'b0;
        sp_idx = 4'd8;
        expect_on("R6", 3);
        sp_idx = 4'd0; cfg_off_en = 1'b1;
        step(1);
    endtask

    task automatic t_save();
        cfg_ctrl_mode = 2'd1; cfg_tgt_mode = 2'd3; cfg_save_en = 1'b1;
        core0_mode = 2'd3;
        step(1);
        check("R8", "save raised", save_req, 1);
        check("R8", "iso untouched", iso_on, 0);
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R8", "save held", save_req, 1);
            check("R8", "switch held", psw_off, 0);
        end
        save_done = 1'b1;
        step(1);
        save_done = 1'b0;
        check("R8", "save dropped", save_req, 0);
        check("R8", "iso after save", iso_on, 1);
        step(1);
        check("R8", "switch after save", psw_off, 1);
        core0_mode = 2'd0;
        expect_up("R8", 0);
        cfg_save_en = 1'b0;
    endtask

    task automatic t_restore();
        cfg_ctrl_mode = 2'd1; cfg_tgt_mode = 2'd1; cfg_rst_run_en = 1'b1;
        core0_mode = 2'd1;
        expect_down("R10");
        core0_mode = 2'd0;
        expect_up("R10", 1);
        cfg_rst_run_en = 1'b0;
        cfg_ctrl_mode = 2'd2; cfg_sp_map = 16'h0100; cfg_rst_sp_map = 16'h0008;
        sp_idx = 4'd8;
        expect_down("R10");
        sp_idx = 4'd3;
        expect_up("R10", 1);
        sp_idx = 4'd8;
        expect_down("R10");
        sp_idx = 4'd0;
        expect_up("R10", 0);
        cfg_rst_sp_map = '0;
    endtask

    task automatic t_defer();
        cfg_ctrl_mode = 2'd1; cfg_tgt_mode = 2'd2; cfg_save_en = 1'b1;
        core0_mode = 2'd2;
        step(1);
        check("R12", "in save", save_req, 1);
        core0_mode = 2'd0;
        step(2);
        check("R12", "save kept after trigger gone", save_req, 1);
        save_done = 1'b1;
        step(1);
        save_done = 1'b0;
        check("R12", "iso continues", iso_on, 1);
        step(1);
        check("R12", "off reached", psw_off, 1);
        expect_up("R12", 0);
        cfg_save_en = 1'b0;
        cfg_save_en = 1'b0;
        core0_mode = 2'd2;
        expect_down("R12");
        core0_mode = 2'd0;
        step(2);
        check("R12", "settling", dom_status, 2);
        core0_mode = 2'd2;
        step(SETTLE - 1);
        check("R12", "settle finished first", dom_status, 0);
        step(1);
        check("R12", "new trigger acted", iso_on, 1);
        step(1);
        check("R12", "deferred power-down", psw_off, 1);
        core0_mode = 2'd0;
        expect_up("R12", 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_sw();
        t_cpu();
        t_sp();
        t_save();
        t_restore();
        t_defer();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule